// File: doc/BRIEF.md
# Switched Front-End Phase Sequencer

This block drives the timing of a clocked charge-amplifier front end in a pixel array. It produces three control lines. The amplifier-reset line closes the feedback switch of the charge amplifier. The clamp line pins the discriminator input to its fixed baseline. The sample line strobes the dynamic discriminator. After each sample strobe it also emits a one-clock hit-valid pulse, which tells downstream capture logic that the discriminator outputs are settled and may be latched.

Every interval is counted in cycles of the fast system clock: the pulse widths, the amount by which clamp overlaps the amplifier reset, the gap before the sample strobe, and the cycle period. A period setting of zero selects a default of 100 clocks, which gives a 1 µs cycle at 100 MHz. The settings are sanitized and then captured only when a cycle starts. The block runs either continuously while enabled, or one cycle per trigger pulse in single-shot mode. When enable is removed, the cycle in progress always completes.

Top module: `fe_phase_seq`

## Requirements
- R1: While `rst` is high, and afterwards until a cycle is started, `amp_rst`, `clamp`, `sample` and `hit_valid` are all low.
- R2: Each cycle begins with `amp_rst` rising. `amp_rst` then stays high for max(2, `cfg_rst_len`) clocks.
- R3: `clamp` rises o clocks before `amp_rst` falls and stays high for c = max(2, `cfg_clamp_len`) clocks. Here o is `cfg_overlap` limited to the range 1 to min(reset width, c) − 1.
- R4: `sample` rises max(1, `cfg_gap`) clocks after `clamp` falls and stays high for max(1, `cfg_smp_len`) clocks. It is never high in the same clock as `amp_rst` or `clamp`.
- R5: `hit_valid` is high for exactly one clock in each cycle, namely the first clock after `sample` falls. It never pulses at any other time.
- R6: The distance in clocks between consecutive `amp_rst` rises is the requested period. If the requested period is not larger than the sample end offset (counted from the cycle start), the distance becomes that offset plus one.
- R7: A `cfg_period` of 0 selects the parameter default period, DEF_PERIOD = 100 clocks.
- R8: Settings are captured only at a cycle start. A change made during a cycle first takes effect in the next cycle.
- R9: When `en` is low at the end of a cycle, no further cycle starts and all outputs stay low. The cycle in progress completes, including its `hit_valid`.
- R10: With `single` high, each `trig` pulse seen while the sequencer is idle and `en` is high runs exactly one cycle. A `trig` pulse that arrives during a running cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable, checked at each cycle boundary |
| single | input | 1 | 1 = one cycle per trigger, 0 = continuous |
| trig | input | 1 | Start pulse for single-shot mode |
| cfg_period | input | CW | Cycle period in clocks, 0 = default |
| cfg_rst_len | input | PW | Amplifier reset width |
| cfg_overlap | input | PW | Clamp/reset overlap |
| cfg_clamp_len | input | PW | Clamp width |
| cfg_gap | input | PW | Clocks from clamp release to sample |
| cfg_smp_len | input | PW | Sample strobe width |
| amp_rst | output | 1 | Amplifier feedback reset phase |
| clamp | output | 1 | Baseline clamp phase |
| sample | output | 1 | Discriminator strobe phase |
| hit_valid | output | 1 | One-clock pulse after sample ends |

## Verification
Suppose the cycle counter or the captured schedule holds a wrong value. That shows up within one cycle as a shifted edge in the reset, clamp or sample line, or as a wrong distance between reset rises. Every edge offset is therefore compared against an expected schedule for each cycle. A broken run/idle state shows up either as an extra cycle after enable falls or after an ignored trigger, or as a missing hit-valid pulse. Counting reset rises over a long idle window detects it.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned SEQ_CW = 16;
  typedef logic [SEQ_CW-1:0] tick_t;

  // Offsets from cycle start, all in system clocks
  typedef struct packed {
    tick_t rst_end;
    tick_t clp_on;
    tick_t clp_off;
    tick_t smp_on;
    tick_t smp_off;
    tick_t per;
  } sched_t;
endpackage

// File: rtl/fps_cfg_latch.sv
module fps_cfg_latch
  import fps_pkg::*;
#(
  parameter int PW         = 8,
  parameter int DEF_PERIOD = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  tick_t           period,
  input  logic [PW-1:0]   rst_len,
  input  logic [PW-1:0]   overlap,
  input  logic [PW-1:0]   clamp_len,
  input  logic [PW-1:0]   gap,
  input  logic [PW-1:0]   smp_len,
  output sched_t          sched_q
);
  tick_t r_w, c_w, o_max, o_w, g_w, s_w, per_req;
  sched_t nxt;

  always_comb begin
    r_w   = (tick_t'(rst_len) < tick_t'(2)) ? tick_t'(2) : tick_t'(rst_len);
    c_w   = (tick_t'(clamp_len) < tick_t'(2)) ? tick_t'(2) : tick_t'(clamp_len);
    o_max = ((r_w < c_w) ? r_w : c_w) - tick_t'(1);
    if (overlap == '0)
      o_w = tick_t'(1);
    else if (tick_t'(overlap) > o_max)
      o_w = o_max;
    else
      o_w = tick_t'(overlap);
    g_w = (gap == '0) ? tick_t'(1) : tick_t'(gap);
    s_w = (smp_len == '0) ? tick_t'(1) : tick_t'(smp_len);
    per_req = (period == '0) ? tick_t'(DEF_PERIOD) : period;

    nxt.rst_end = r_w;
    nxt.clp_on  = r_w - o_w;
    nxt.clp_off = nxt.clp_on + c_w;
    nxt.smp_on  = nxt.clp_off + g_w;
    nxt.smp_off = nxt.smp_on + s_w;
    nxt.per     = (per_req > nxt.smp_off) ? per_req : nxt.smp_off + tick_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sched_q <= '0;
    end else if (load) begin
      sched_q <= nxt;
    end
  end

  // R8: schedule only moves at a cycle start
  a_r8_sched_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sched_q));
  // R6: captured period always leaves room for hit_valid
  a_r6_per_fits: assert property (@(posedge clk) disable iff (rst)
    load |=> (sched_q.per > sched_q.smp_off));
endmodule

// File: rtl/fps_timer.sv
module fps_timer
  import fps_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  single,
  input  logic  trig,
  input  tick_t per,
  output logic  run_q,
  output tick_t cnt_q,
  output logic  load
);
  logic last, start_idle, go_on;

  always_comb begin
    last       = run_q && (cnt_q == per - tick_t'(1));
    start_idle = !run_q && en && (single ? trig : 1'b1);
    go_on      = last && en && !single;
    load       = start_idle || go_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      cnt_q <= '0;
      if (start_idle) run_q <= 1'b1;
    end else if (last) begin
      cnt_q <= '0;
      if (!go_on) run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + tick_t'(1);
    end
  end

  // R6: counter stays inside the captured period
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < per));
  // R9: no cycle follows a boundary with enable low
  a_r9_stop: assert property (@(posedge clk) disable iff (rst)
    (last && !en) |=> !run_q);
  // R10: single-shot never chains cycles
  a_r10_one_shot: assert property (@(posedge clk) disable iff (rst)
    (last && single) |=> !run_q);
endmodule

// File: rtl/fps_phase_gen.sv
module fps_phase_gen
  import fps_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  tick_t  cnt,
  input  sched_t sch,
  output logic   amp_rst_q,
  output logic   clamp_q,
  output logic   sample_q,
  output logic   hv_q
);
  logic rst_d, clp_d, smp_d, hv_d;

  always_comb begin
    rst_d = run && (cnt < sch.rst_end);
    clp_d = run && (cnt >= sch.clp_on) && (cnt < sch.clp_off);
    smp_d = run && (cnt >= sch.smp_on) && (cnt < sch.smp_off);
    hv_d  = run && (cnt == sch.smp_off);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_rst_q <= 1'b0;
      clamp_q   <= 1'b0;
      sample_q  <= 1'b0;
      hv_q      <= 1'b0;
    end else begin
      amp_rst_q <= rst_d;
      clamp_q   <= clp_d;
      sample_q  <= smp_d;
      hv_q      <= hv_d;
    end
  end

  a_r4_sample_excl: assert property (@(posedge clk) disable iff (rst)
    sample_q |-> (!amp_rst_q && !clamp_q));
  a_r3_clamp_overlaps: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_q) |-> amp_rst_q);
  a_r2_start_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_rst_q) |-> (!clamp_q && !sample_q));
  a_r5_hv_after_sample: assert property (@(posedge clk) disable iff (rst)
    hv_q |-> ($past(sample_q) && !sample_q));
  a_r5_hv_single: assert property (@(posedge clk) disable iff (rst)
    hv_q |=> !hv_q);
endmodule

// File: rtl/fe_phase_seq.sv
module fe_phase_seq
  import fps_pkg::*;
#(
  parameter int PW         = 8,
  parameter int CW         = fps_pkg::SEQ_CW,
  parameter int DEF_PERIOD = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          single,
  input  logic          trig,
  input  logic [CW-1:0] cfg_period,
  input  logic [PW-1:0] cfg_rst_len,
  input  logic [PW-1:0] cfg_overlap,
  input  logic [PW-1:0] cfg_clamp_len,
  input  logic [PW-1:0] cfg_gap,
  input  logic [PW-1:0] cfg_smp_len,
  output logic          amp_rst,
  output logic          clamp,
  output logic          sample,
  output logic          hit_valid
);
  sched_t sched;
  tick_t  cnt;
  logic   run, load;

  fps_cfg_latch #(.PW(PW), .DEF_PERIOD(DEF_PERIOD)) u_cfg (
    .clk(clk), .rst(rst), .load(load),
    .period(tick_t'(cfg_period)), .rst_len(cfg_rst_len), .overlap(cfg_overlap),
    .clamp_len(cfg_clamp_len), .gap(cfg_gap), .smp_len(cfg_smp_len),
    .sched_q(sched)
  );

  fps_timer u_tmr (
    .clk(clk), .rst(rst), .en(en), .single(single), .trig(trig),
    .per(sched.per), .run_q(run), .cnt_q(cnt), .load(load)
  );

  fps_phase_gen u_gen (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .sch(sched),
    .amp_rst_q(amp_rst), .clamp_q(clamp), .sample_q(sample), .hv_q(hit_valid)
  );

  // R1: idle sequencer drives nothing
  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !(amp_rst || clamp || sample));
endmodule

// File: tb/test_fe_phase_seq.sv
module test_fe_phase_seq;
  localparam int CLK_P = 10;
  localparam int PW = 8;
  localparam int CW = 16;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, single = 1'b0, trig = 1'b0;
  logic [CW-1:0] cfg_period = '0;
  logic [PW-1:0] cfg_rst_len = '0, cfg_overlap = '0, cfg_clamp_len = '0, cfg_gap = '0, cfg_smp_len = '0;
  logic amp_rst, clamp, sample, hit_valid;

  always #(CLK_P/2) clk = ~clk;

  fe_phase_seq i_fe_phase_seq (
    .clk(clk), .rst(rst), .en(en), .single(single), .trig(trig),
    .cfg_period(cfg_period), .cfg_rst_len(cfg_rst_len), .cfg_overlap(cfg_overlap),
    .cfg_clamp_len(cfg_clamp_len), .cfg_gap(cfg_gap), .cfg_smp_len(cfg_smp_len),
    .amp_rst(amp_rst), .clamp(clamp), .sample(sample), .hit_valid(hit_valid)
  );

  typedef struct { int r; int con; int coff; int son; int soff; int per; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0, n_rise = 0, n_hv = 0;
  int t = 0, last_period = 0, m_rf = 0, m_cr = 0, m_cf = 0, m_sr = 0, m_sf = 0;
  logic p_r = 0, p_c = 0, p_s = 0, p_h = 0, done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(int rl, int ov, int cl, int gp, int sl, int pr);
    exp_t e; int c, m, o, pp;
    e.r = (rl < 2) ? 2 : rl;
    c = (cl < 2) ? 2 : cl;
    m = ((e.r < c) ? e.r : c) - 1;
    o = (ov < 1) ? 1 : ((ov > m) ? m : ov);
    e.con = e.r - o;
    e.coff = e.con + c;
    e.son = e.coff + ((gp < 1) ? 1 : gp);
    e.soff = e.son + ((sl < 1) ? 1 : sl);
    pp = (pr == 0) ? 100 : pr;
    e.per = (pp > e.soff) ? pp : e.soff + 1;
    return e;
  endfunction

  task automatic set_cfg(int rl, int ov, int cl, int gp, int sl, int pr);
    cfg_rst_len = PW'(rl); cfg_overlap = PW'(ov); cfg_clamp_len = PW'(cl);
    cfg_gap = PW'(gp); cfg_smp_len = PW'(sl); cfg_period = CW'(pr);
  endtask

  // driver side: push expected cycle schedules
  task automatic push(int rl, int ov, int cl, int gp, int sl, int pr, int n);
    for (int i = 0; i < n; i++) q.push_back(mk(rl, ov, cl, gp, sl, pr));
  endtask

  task automatic wait_rise(int n);
    int tgt = n_rise + n;
    while (n_rise < tgt) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  // monitor: measure edge offsets from each amp_rst rise, compare at hit_valid
  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      t = t + 1;
      if (amp_rst && !p_r) begin last_period = t; t = 0; n_rise++; end
      if (!amp_rst && p_r) m_rf = t;
      if (clamp && !p_c) m_cr = t;
      if (!clamp && p_c) m_cf = t;
      if (sample && !p_s) m_sr = t;
      if (!sample && p_s) m_sf = t;
      if (sample && (amp_rst || clamp)) chk("R4 sample exclusive", 1, 0);
      if (hit_valid && p_h) chk("R5 hit_valid one clock", 1, 0);
      if (hit_valid) begin
        n_hv++;
        if (q.size() == 0) chk("R5 unexpected hit_valid", 1, 0);
        else begin
          e = q.pop_front();
          chk("R2 reset width", m_rf, e.r);
          chk("R3 clamp rise", m_cr, e.con);
          chk("R3 clamp fall", m_cf, e.coff);
          chk("R4 sample rise", m_sr, e.son);
          chk("R4 sample fall", m_sf, e.soff);
          chk("R5 hit_valid slot", t, e.soff);
        end
      end
      p_r = amp_rst; p_c = clamp; p_s = sample; p_h = hit_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r0;
    exp_t e;
    idle(5);
    // R1 reset state
    chk("R1 amp_rst in reset", int'(amp_rst), 0);
    chk("R1 clamp in reset", int'(clamp), 0);
    chk("R1 sample in reset", int'(sample), 0);
    chk("R1 hit_valid in reset", int'(hit_valid), 0);
    rst = 1'b0;
    idle(20);
    chk("R1 idle without enable", int'(amp_rst | clamp | sample | hit_valid), 0);

    // continuous, nominal schedule; R6 period, R9 stop after drop
    set_cfg(10, 3, 20, 5, 8, 100);
    push(10, 3, 20, 5, 8, 100, 3);
    r0 = n_rise;
    en = 1'b1; wait_rise(3); en = 1'b0;
    chk("R6 nominal period", last_period, 100);
    idle(300);
    chk("R9 no cycle after enable drop", n_rise - r0, 3);
    chk("R9 outputs low", int'(amp_rst | clamp | sample | hit_valid), 0);

    // R7 default period
    set_cfg(10, 3, 20, 5, 8, 0);
    push(10, 3, 20, 5, 8, 0, 2);
    en = 1'b1; wait_rise(2); en = 1'b0;
    chk("R7 default period", last_period, 100);
    idle(250);

    // R6 period stretched to fit the schedule
    set_cfg(4, 1, 5, 2, 3, 5);
    push(4, 1, 5, 2, 3, 5, 3);
    e = mk(4, 1, 5, 2, 3, 5);
    en = 1'b1; wait_rise(3); en = 1'b0;
    chk("R6 stretched period", last_period, e.per);
    idle(100);

    // R2/R3/R4 sanitizing of degenerate settings
    set_cfg(0, 9, 0, 0, 0, 3);
    push(0, 9, 0, 0, 0, 3, 2);
    en = 1'b1; wait_rise(2); en = 1'b0;
    chk("R6 minimal period", last_period, 6);
    idle(100);

    // R8 mid-cycle change applies to next cycle only
    set_cfg(10, 3, 20, 5, 8, 100);
    push(10, 3, 20, 5, 8, 100, 1);
    r0 = n_rise;
    en = 1'b1; wait_rise(1);
    set_cfg(6, 2, 8, 3, 4, 60);
    push(6, 2, 8, 3, 4, 60, 1);
    wait_rise(1); en = 1'b0;
    chk("R8 first period unchanged", last_period, 100);
    idle(200);
    chk("R9 cycle count after change", n_rise - r0, 2);

    // R10 single-shot
    single = 1'b1; en = 1'b1;
    r0 = n_rise;
    idle(50);
    chk("R10 no start without trig", n_rise - r0, 0);
    push(6, 2, 8, 3, 4, 60, 1);
    pulse_trig();
    wait_rise(1);
    idle(5);
    pulse_trig();   // during run: ignored
    idle(200);
    chk("R10 one cycle per trigger", n_rise - r0, 1);
    push(6, 2, 8, 3, 4, 60, 1);
    pulse_trig();
    idle(200);
    chk("R10 second trigger", n_rise - r0, 2);
    chk("R10 outputs low after shot", int'(amp_rst | clamp | sample | hit_valid), 0);
    chk("R5 every cycle gave hit_valid", q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule